// File: doc/BRIEF.md
# DDR3 Refresh Interval Scheduler

This block sits beside the command arbiter of a DDR3 controller and decides when a REFRESH must be issued. It counts clocks since the most recent accepted refresh, raises a refresh request a set lead time before the longest permitted gap, and raises an urgent flag once a shorter lead is also used up. The arbiter issues REFRESH and pulses the acknowledge in the same cycle that it sees the request. An acknowledge with no request is ignored.

The request is only offered while every bank is reported closed, and never during the activate blackout that follows a refresh. Refreshes can be grouped into bursts of a configurable size. The longest gap then grows to BURST x INTERVAL minus (BURST-1) x RFC clocks. Within a burst, the request comes back after each blackout until the whole burst has been issued. Row activation is held off for the whole burst. A one-cycle pulse marks the completion of each burst.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ref_req_o, ref_urgent_o, act_inhibit_o and burst_done_o are all low.
- R2: LIMIT = BURST*INTERVAL - (BURST-1)*RFC. With no burst in progress, ref_req_o rises once the count of clocks since the last accepted refresh (counting from reset) reaches LIMIT-REQ_LEAD, provided banks_closed_i is high and no blackout is running.
- R3: ref_urgent_o is high while the count is at least LIMIT-URG_LEAD. It stays high until a refresh is accepted. The count saturates at LIMIT.
- R4: ref_req_o is low in any cycle where banks_closed_i is low. It returns in the same cycle that banks_closed_i goes high again.
- R5: A refresh is accepted only when ref_ack_i and ref_req_o are both high in the same cycle. An acknowledge at any other time changes nothing.
- R6: An accepted refresh clears the count. In the next cycle ref_req_o and ref_urgent_o are low.
- R7: act_inhibit_o is high for exactly RFC cycles after each accepted refresh, starting in the cycle after acceptance.
- R8: After a refresh that is not the last of its burst, ref_req_o rises again when the blackout ends. act_inhibit_o stays high until the last refresh of the burst plus its blackout.
- R9: burst_done_o is high for exactly one cycle, in the cycle after the last refresh of a burst is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_closed_i | input | 1 | All banks are precharged |
| ref_ack_i | input | 1 | REFRESH issued this cycle |
| ref_req_o | output | 1 | A refresh may and should be issued now |
| ref_urgent_o | output | 1 | The refresh deadline is close |
| act_inhibit_o | output | 1 | ACTIVATE is not allowed |
| burst_done_o | output | 1 | Last refresh of a burst was accepted |

## Verification
The count is at n after the n-th clock edge following reset or an accepted refresh. The request is therefore due in the cycle after edge LIMIT-REQ_LEAD, and the urgent flag after edge LIMIT-URG_LEAD. Acceptance takes effect at the edge that samples the acknowledge. The blackout, the drop of the request and the completion pulse all appear in the cycle right after that edge, and the inhibit clears RFC edges later. The scoreboard holds each expected value against the exact cycle number at which it is due, and compares it half a period after that edge. A single value at the edge before and the edge after a transition checks its timing to the cycle.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    // Longest legal distance between two refresh bursts, in clocks.
    function automatic int gap_limit(input int n_burst, input int ival, input int rfc);
        return n_burst * ival - (n_burst - 1) * rfc;
    endfunction

    function automatic int width_for(input int maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/rfsh_gap_counter.sv
module rfsh_gap_counter
    import rfsh_pkg::*;
#(
    parameter int LIMIT    = 1560,
    parameter int REQ_LEAD = 200,
    parameter int URG_LEAD = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic due_o,
    output logic urgent_o
);
    localparam int CW = width_for(LIMIT);
    localparam logic [CW-1:0] TOP    = CW'(LIMIT);
    localparam logic [CW-1:0] REQ_AT = CW'(LIMIT - REQ_LEAD);
    localparam logic [CW-1:0] URG_AT = CW'(LIMIT - URG_LEAD);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } gap_s;

    gap_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)
            st_d.cnt = '0;
        else if (st_q.cnt != TOP)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign due_o    = (st_q.cnt >= REQ_AT);
    assign urgent_o = (st_q.cnt >= URG_AT);

    // urgency never comes ahead of the plain request threshold
    p_urgent_after_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
        urgent_o |-> due_o);

endmodule

// File: rtl/rfsh_blackout.sv
module rfsh_blackout
    import rfsh_pkg::*;
#(
    parameter int RFC = 320
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int BW = width_for(RFC);

    typedef struct packed {
        logic [BW-1:0] left;
    } blk_s;

    blk_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i)
            st_d.left = BW'(RFC);
        else if (st_q.left != '0)
            st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.left != '0);

    p_busy_fall_only_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !$past(load_i));

endmodule

// File: rtl/rfsh_burst_tracker.sv
module rfsh_burst_tracker
    import rfsh_pkg::*;
#(
    parameter int BURST = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    output logic in_burst_o,
    output logic done_o
);
    localparam int LW = width_for(BURST - 1);

    typedef struct packed {
        logic [LW-1:0] left;
        logic          done;
    } bt_s;

    bt_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept_i) begin
            if (st_q.left == '0) begin
                st_d.left = LW'(BURST - 1);
                st_d.done = (BURST == 1);
            end else begin
                st_d.left = st_q.left - 1'b1;
                st_d.done = (st_q.left == LW'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_burst_o = (st_q.left != '0);
    assign done_o     = st_q.done;

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_follows_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(accept_i));

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int INTERVAL = 1560,
    parameter int RFC      = 320,
    parameter int BURST    = 1,
    parameter int REQ_LEAD = 200,
    parameter int URG_LEAD = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic banks_closed_i,
    input  logic ref_ack_i,
    output logic ref_req_o,
    output logic ref_urgent_o,
    output logic act_inhibit_o,
    output logic burst_done_o
);
    localparam int LIMIT = gap_limit(BURST, INTERVAL, RFC);

    logic due, urgent, busy, in_burst, accept;

    assign ref_req_o     = (due || in_burst) && banks_closed_i && !busy;
    assign accept        = ref_ack_i && ref_req_o;
    assign ref_urgent_o  = urgent;
    assign act_inhibit_o = busy || in_burst;

    rfsh_gap_counter #(
        .LIMIT(LIMIT), .REQ_LEAD(REQ_LEAD), .URG_LEAD(URG_LEAD)
    ) u_gap (
        .clk(clk), .rst_n(rst_n), .clr_i(accept), .due_o(due), .urgent_o(urgent)
    );

    rfsh_blackout #(.RFC(RFC)) u_blk (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .busy_o(busy)
    );

    rfsh_burst_tracker #(.BURST(BURST)) u_burst (
        .clk(clk), .rst_n(rst_n), .accept_i(accept),
        .in_burst_o(in_burst), .done_o(burst_done_o)
    );

    p_req_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ack_i && ref_req_o) |=> !ref_req_o);
    p_inhibit_after_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ack_i && ref_req_o) |=> act_inhibit_o);
    p_urgent_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_urgent_o && !(ref_ack_i && ref_req_o)) |=> ref_urgent_o);
    p_req_needs_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> banks_closed_i);

endmodule

// File: tb/sim_rfsh_sched.sv
module sim_rfsh_sched;
    localparam int INTERVAL = 100;
    localparam int RFC      = 20;
    localparam int BURST    = 2;
    localparam int REQ_LEAD = 30;
    localparam int URG_LEAD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic closed = 1'b1;
    logic ack = 1'b0;
    logic req, urg, inh, done;
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    typedef struct {
        int    at;
        int    sig;
        bit    val;
        string tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    rfsh_sched #(
        .INTERVAL(INTERVAL), .RFC(RFC), .BURST(BURST),
        .REQ_LEAD(REQ_LEAD), .URG_LEAD(URG_LEAD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .banks_closed_i(closed), .ref_ack_i(ack),
        .ref_req_o(req), .ref_urgent_o(urg), .act_inhibit_o(inh),
        .burst_done_o(done)
    );

    // signal codes: 0 req, 1 urgent, 2 inhibit, 3 done
    task automatic expect_at(input int at, input int sig, input bit val, input string tag);
        item_t it;
        it.at = at; it.sig = sig; it.val = val; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic after_edge(input int n);
        do begin
            @(posedge clk);
            #1;
        end while (cyc != n);
    endtask

    function automatic bit pick(input int sig);
        case (sig)
            0: return req;
            1: return urg;
            2: return inh;
            default: return done;
        endcase
    endfunction

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                while (sb.size() > 0 && sb[0].at <= cyc) begin
                    item_t it;
                    bit    got;
                    it  = sb.pop_front();
                    got = pick(it.sig);
                    total++;
                    if (it.at != cyc || got !== it.val) begin
                        bad++;
                        $display("FAIL %s cyc=%0d sig=%0d actual=%0b expected=%0b",
                                 it.tag, it.at, it.sig, got, it.val);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        #100000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // driver
    initial begin
        // LIMIT = 2*100-20 = 180, request at 150, urgent at 170
        expect_at(0,   0, 1'b0, "R1");
        expect_at(0,   1, 1'b0, "R1");
        expect_at(0,   2, 1'b0, "R1");
        expect_at(0,   3, 1'b0, "R1");
        expect_at(101, 2, 1'b0, "R5");
        expect_at(149, 0, 1'b0, "R2");
        expect_at(150, 0, 1'b1, "R2");
        expect_at(155, 0, 1'b0, "R4");
        expect_at(161, 2, 1'b0, "R5");
        expect_at(169, 1, 1'b0, "R3");
        expect_at(170, 1, 1'b1, "R3");
        expect_at(175, 0, 1'b1, "R4");
        expect_at(176, 1, 1'b1, "R3");
        expect_at(177, 0, 1'b0, "R6");
        expect_at(177, 1, 1'b0, "R6");
        expect_at(177, 2, 1'b1, "R7");
        expect_at(177, 3, 1'b0, "R9");
        expect_at(196, 0, 1'b0, "R8");
        expect_at(197, 0, 1'b1, "R8");
        expect_at(197, 2, 1'b1, "R8");
        expect_at(199, 0, 1'b0, "R6");
        expect_at(199, 2, 1'b1, "R7");
        expect_at(199, 3, 1'b1, "R9");
        expect_at(200, 3, 1'b0, "R9");
        expect_at(218, 2, 1'b1, "R7");
        expect_at(219, 2, 1'b0, "R7");
        expect_at(348, 0, 1'b0, "R2");
        expect_at(349, 0, 1'b1, "R2");

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        after_edge(100); ack = 1'b1;     // no request: ignored (R5)
        after_edge(101); ack = 1'b0;
        after_edge(155); closed = 1'b0;  // request gated (R4)
        after_edge(160); ack = 1'b1;     // ignored while gated (R5)
        after_edge(161); ack = 1'b0;
        after_edge(175); closed = 1'b1;
        after_edge(176); ack = 1'b1;     // first of burst accepted at edge 177
        after_edge(177); ack = 1'b0;
        after_edge(198); ack = 1'b1;     // second accepted at edge 199
        after_edge(199); ack = 1'b0;
        after_edge(355);

        if (sb.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sb.size());
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule